// File: doc/BRIEF.md
# Fetch-Pattern Scanline Interrupt Detector

This block works out where a video controller is in its frame without any sync signal from it. It watches the controller's memory read strobe and address, and it watches the CPU clock-enable strobe. When the controller reads the same name-table address three times in a row, the read after that marks the start of a scanline. A short gap in video reads, measured in CPU cycles, marks the end of the visible frame. From these events the block keeps an in-frame flag and an 8-bit scanline count. It raises a pending flag when the count reaches a target that software programs.

Software sees two registers. Register select 0 holds the target and is write-only; it reads as zero. Register select 1 is the control/status register: a write sets the interrupt enable, and a read returns status and acknowledges the interrupt. A CPU fetch of the interrupt vector clears the frame tracking, so every frame starts clean. The IRQ output is high while the pending flag and the enable are both set.

Frame tracking is a three-state machine, listed here with its transitions:
- OUT: no frame is being tracked. A scanline start moves it to ARMED and zeroes the count.
- ARMED: the block is waiting for the next name-table fetch, which moves it to IN.
- IN: inside the frame. An idle timeout or a vector fetch moves it back to OUT. In ARMED, a vector fetch changes only the count and the pending flag, not the state.

Top module: `scanline_irq_detector`

## Requirements
- R1: After reset the IRQ output is low, and a status read returns 0x00.
- R2: A video read is a scanline start when the three video reads before it were all in 0x2000–0x2FFF and all at one address. A read outside that range breaks the run, and so does a read at a different address.
- R3: A scanline start in state OUT moves to ARMED and zeroes the count. It never sets pending, even when the target is 0, and it does not show as in-frame.
- R4: In ARMED, the next name-table fetch moves to IN. A name-table fetch is a read in 0x2000–0x2FFF whose low 10 address bits are below 0x3C0. Status bit 6 is high only in IN.
- R5: A scanline start in ARMED or IN adds one to the count. Pending is set when the new count equals the target.
- R6: Every video read reloads an idle count of 3. Each CPU tick without a video read lowers it. When it reaches 0 in state IN, the state goes to OUT.
- R7: A status read (select 1) returns bit 7 = pending and bit 6 = in-frame, with the other bits 0. It then clears pending.
- R8: A control write (select 1) sets the enable from data bit 7. IRQ = pending AND enable, so enabling while pending raises IRQ on the next cycle.
- R9: A vector fetch clears pending, the count and the stored last address, and moves IN to OUT. It takes priority over a scanline start in the same cycle.
- R10: The count is 8 bits wide and wraps from 255 to 0. With target 0, pending is set on the 256th increment.
- R11: When a video read and a CPU tick arrive in the same cycle, the reload wins and the idle count does not go down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_rd | input | 1 | One-cycle strobe: the video controller made a memory read |
| vid_addr | input | 14 | Video read address |
| cpu_tick | input | 1 | One-cycle strobe: one CPU cycle has passed |
| vec_fetch | input | 1 | One-cycle strobe: the CPU fetched the interrupt vector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | Register select: 0 = target, 1 = control/status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data; status when select is 1, zero when select is 0 |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench targets six corner cases, each of which a faulty design would get visibly wrong:
- A repeat run broken by a pattern-table read or by a different address. A design that ignores the break would arm early.
- Attribute-table reads while ARMED. A design that treats them as name-table fetches would report in-frame too soon.
- A video read and a CPU tick in the same cycle. A design that lets the tick win would leave the frame one gap too early.
- The first scanline start with target 0. Comparing on arming would fire at once.
- A vector fetch made in ARMED. If the count is not cleared, pending comes one line early.
- A full 256-line wrap with target 0. A count that saturates, or is wider than 8 bits, would never fire.

// File: rtl/sid_pkg.sv
package sid_pkg;

    typedef enum logic [1:0] {
        FR_OUT   = 2'd0,
        FR_ARMED = 2'd1,
        FR_IN    = 2'd2
    } frame_state_t;

    // Video reads in 0x2000-0x2FFF belong to the name/attribute tables
    function automatic logic in_table_space(input logic [13:0] a);
        return a[13:12] == 2'b10;
    endfunction

    // Name-table fetch: table space, low 10 bits below 0x3C0
    function automatic logic is_name_fetch(input logic [13:0] a);
        return (a[13:12] == 2'b10) && (a[9:6] != 4'hF);
    endfunction

endpackage

// File: rtl/fetch_repeat_tracker.sv
module fetch_repeat_tracker #(
    parameter int ADDR_W       = 14,
    parameter int REPEAT_LIMIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              in_range,
    input  logic [ADDR_W-1:0] addr,
    input  logic              forget,
    output logic              line_start
);
    localparam int REP_W = $clog2(REPEAT_LIMIT + 1);

    logic [REP_W-1:0]  rep_q;
    logic [ADDR_W-1:0] last_q;

    assign line_start = rd && (rep_q >= REP_W'(REPEAT_LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q <= '0;
        end else if (rd) begin
            if (line_start)
                rep_q <= '0;
            else if (in_range && (addr == last_q))
                rep_q <= rep_q + 1'b1;
            else
                rep_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_q <= '0;
        else if (forget)
            last_q <= '0;
        else if (rd)
            last_q <= addr;
    end
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
    parameter int IDLE_RELOAD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic tick,
    output logic expire
);
    localparam int IDLE_W = $clog2(IDLE_RELOAD + 1);

    logic [IDLE_W-1:0] cnt_q;

    assign expire = tick && !rd && (cnt_q == IDLE_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (rd)
            cnt_q <= IDLE_W'(IDLE_RELOAD);
        else if (tick && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/frame_tracker.sv
module frame_tracker
    import sid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic name_fetch,
    input  logic line_start,
    input  logic expire,
    input  logic vec,
    output logic in_frame,
    output logic is_out
);
    frame_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_OUT:   if (line_start)           state_d = FR_ARMED;
            FR_ARMED: if (name_fetch && !vec)   state_d = FR_IN;
            FR_IN:    if (expire || vec)        state_d = FR_OUT;
            default:                            state_d = FR_OUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FR_OUT;
        else
            state_q <= state_d;
    end

    always_comb begin
        in_frame = 1'b0;
        is_out   = 1'b0;
        unique case (state_q)
            FR_OUT:   is_out   = 1'b1;
            FR_ARMED: ;
            FR_IN:    in_frame = 1'b1;
            default:  is_out   = 1'b1;
        endcase
    end
endmodule

// File: rtl/line_counter_irq.sv
module line_counter_irq #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             restart,
    input  logic             vec,
    input  logic             ack,
    input  logic [CNT_W-1:0] target,
    output logic             pending
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             hit;

    assign cnt_inc = cnt_q + 1'b1;
    assign hit     = line_start && !restart && (cnt_inc == target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (vec)
            cnt_q <= '0;
        else if (line_start)
            cnt_q <= restart ? '0 : cnt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (vec)
            pending <= 1'b0;
        else if (hit)
            pending <= 1'b1;
        else if (ack)
            pending <= 1'b0;
    end
endmodule

// File: rtl/scanline_irq_detector.sv
module scanline_irq_detector
    import sid_pkg::*;
#(
    parameter int ADDR_W       = 14,
    parameter int CNT_W        = 8,
    parameter int IDLE_RELOAD  = 3,
    parameter int REPEAT_LIMIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_rd,
    input  logic [ADDR_W-1:0] vid_addr,
    input  logic              cpu_tick,
    input  logic              vec_fetch,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    localparam int ENABLE_BIT  = 7;
    localparam int PEND_BIT    = 7;
    localparam int INFRAME_BIT = 6;

    logic [CNT_W-1:0] target_q;
    logic             enable_q;
    logic             in_range;
    logic             name_fetch;
    logic             line_start;
    logic             expire;
    logic             in_frame;
    logic             is_out;
    logic             pending;
    logic             status_ack;

    assign in_range   = in_table_space(vid_addr[13:0]);
    assign name_fetch = vid_rd && is_name_fetch(vid_addr[13:0]);
    assign status_ack = reg_rd && reg_sel;

    fetch_repeat_tracker #(
        .ADDR_W       (ADDR_W),
        .REPEAT_LIMIT (REPEAT_LIMIT)
    ) u_rep (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (vid_rd),
        .in_range   (in_range),
        .addr       (vid_addr),
        .forget     (vec_fetch),
        .line_start (line_start)
    );

    idle_timer #(
        .IDLE_RELOAD (IDLE_RELOAD)
    ) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (vid_rd),
        .tick   (cpu_tick),
        .expire (expire)
    );

    frame_tracker u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .name_fetch (name_fetch),
        .line_start (line_start),
        .expire     (expire),
        .vec        (vec_fetch),
        .in_frame   (in_frame),
        .is_out     (is_out)
    );

    line_counter_irq #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start && !vec_fetch),
        .restart    (is_out),
        .vec        (vec_fetch),
        .ack        (status_ack),
        .target     (target_q),
        .pending    (pending)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
            enable_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_sel)
                enable_q <= reg_wdata[ENABLE_BIT];
            else
                target_q <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_sel) begin
            reg_rdata[PEND_BIT]    = pending;
            reg_rdata[INFRAME_BIT] = in_frame;
        end
    end

    assign irq = pending && enable_q;
endmodule

// File: rtl/sid_checker.sv
module sid_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       vid_rd,
    input logic       cpu_tick,
    input logic       vec_fetch,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       reg_sel,
    input logic [7:0] reg_wdata,
    input logic       irq,
    input logic       in_frame,
    input logic       pending
);
    AST_DISABLE_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && !reg_wdata[7]) |=> !irq); // R8

    AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel && !vid_rd) |=> !pending); // R7

    AST_VECTOR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fetch |=> (!pending && !in_frame)); // R9

    AST_FRAME_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_frame) |-> $past((cpu_tick && !vid_rd) || vec_fetch)); // R6

    AST_FRAME_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> $past(vid_rd && !vec_fetch)); // R4

    AST_PEND_FROM_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(vid_rd)); // R5
endmodule

bind scanline_irq_detector sid_checker u_sid_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .vid_rd    (vid_rd),
    .cpu_tick  (cpu_tick),
    .vec_fetch (vec_fetch),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .in_frame  (in_frame),
    .pending   (pending)
);

// File: tb/test_scanline_irq_detector.sv
`timescale 1ns/1ps
module test_scanline_irq_detector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vid_rd = 1'b0;
    logic [13:0] vid_addr = '0;
    logic        cpu_tick = 1'b0;
    logic        vec_fetch = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    localparam logic [13:0] NT_A   = 14'h2000;
    localparam logic [13:0] NT_C   = 14'h2005;
    localparam logic [13:0] AT_B   = 14'h23C0;
    localparam logic [13:0] AT_D   = 14'h27C0;
    localparam logic [13:0] AT_E   = 14'h2BC0;
    localparam logic [13:0] PAT    = 14'h0100;

    always #5 clk = ~clk;

    scanline_irq_detector i_scanline_irq_detector (
        .clk(clk), .rst_n(rst_n), .vid_rd(vid_rd), .vid_addr(vid_addr),
        .cpu_tick(cpu_tick), .vec_fetch(vec_fetch), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Monitor: pops an expected status on each status read
    always begin
        @(negedge clk);
        #1;
        if (reg_rd && reg_sel) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected status read: actual %02h expected none", reg_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    errors++;
                    $display("FAIL %s status: actual %02h expected %02h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic vread(input logic [13:0] a);
        @(negedge clk); vid_rd = 1'b1; vid_addr = a;
        @(negedge clk); vid_rd = 1'b0;
    endtask

    task automatic line(input logic [13:0] x, input logic [13:0] y);
        vread(x); vread(x); vread(x); vread(y);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cpu_tick = 1'b1;
            @(negedge clk); cpu_tick = 1'b0;
        end
    endtask

    task automatic wreg(input logic sel, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic vector();
        @(negedge clk); vec_fetch = 1'b1;
        @(negedge clk); vec_fetch = 1'b0;
    endtask

    task automatic expect_status(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk); reg_rd = 1'b1; reg_sel = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk); #1;
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq: actual %0b expected %0b", t, irq, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_irq(1'b0, "R1");
        expect_status(8'h00, "R1");

        wreg(1'b0, 8'd2);
        wreg(1'b1, 8'h80);

        // R2: broken runs never give a scanline start
        vread(NT_A); vread(NT_A); vread(PAT); vread(NT_A); vread(NT_A); vread(NT_C);
        expect_status(8'h00, "R2");

        // R3: arming line, no in-frame
        line(NT_A, AT_B);
        expect_status(8'h00, "R3");

        // R4: attribute read does not enter frame
        vread(AT_B);
        expect_status(8'h00, "R4");
        line(NT_A, AT_B);
        expect_status(8'h40, "R4");

        // R5/R7/R8: count reaches target 2
        line(NT_A, AT_B);
        chk_irq(1'b1, "R8");
        expect_status(8'hC0, "R5");
        expect_status(8'h40, "R7");
        chk_irq(1'b0, "R7");

        // R6: idle timeout
        tick(2);
        expect_status(8'h40, "R6");
        tick(1);
        expect_status(8'h00, "R6");

        // R8: enable while pending
        wreg(1'b1, 8'h00);
        line(NT_A, AT_B);
        line(NT_A, AT_B);
        line(NT_A, AT_B);
        chk_irq(1'b0, "R8");
        wreg(1'b1, 8'h80);
        chk_irq(1'b1, "R8");

        // R9: vector fetch clears pending, frame and count
        vector();
        chk_irq(1'b0, "R9");
        expect_status(8'h00, "R9");
        line(NT_A, AT_B);
        line(AT_D, AT_E);
        vector();
        line(AT_D, AT_E);
        expect_status(8'h00, "R9");
        line(AT_D, AT_E);
        expect_status(8'h80, "R9");

        // R10: wrap with target 0
        vector();
        wreg(1'b0, 8'd0);
        for (int i = 0; i < 255; i++) line(AT_D, AT_E);
        expect_status(8'h00, "R10");
        line(AT_D, AT_E);
        expect_status(8'h80, "R10");

        // R11: read and tick together, reload wins
        vread(NT_A);
        tick(2);
        @(negedge clk); vid_rd = 1'b1; vid_addr = 14'h0000; cpu_tick = 1'b1;
        @(negedge clk); vid_rd = 1'b0; cpu_tick = 1'b0;
        tick(2);
        expect_status(8'h40, "R11");
        tick(1);
        expect_status(8'h00, "R6");

        // R3: arming with target 0 sets no pending
        line(NT_A, AT_B);
        expect_status(8'h00, "R3");
        vread(NT_A);
        expect_status(8'h40, "R3");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule